// File: doc/BRIEF.md
# Bit-Repetition Transmit Oversampler

This block lets a transceiver that runs at a fixed, high serial rate carry a much slower video line. It sends every payload bit several times in a row, either 5 or 11 times. The far end therefore sees the slow line rate, and the transceiver stays in a frequency band it supports. For example, 270 Mbps comes out of a 1,350 Mbps lane at 5 repeats, and the 11-repeat setting suits a lane running at 2,970 Mbps.

Ten-bit video samples arrive with a qualifier, and the block pairs them into 20-bit words. The words are held in a small single-clock buffer. A fixed-cadence fetch takes one word from the buffer once per output word period, every 5 or 11 core clocks. On every core clock the block presents one 20-bit transceiver word holding the repeated bits, least significant bit first. The fetch never stalls. When the buffer is empty at a fetch, the block flags the event and sends the previous word again.

Top module: `txos_oversampler`

## Requirements
- R1: While reset is low and on the first cycle after it, txWord is zero, slotPulse and underflow are low, fifoEmpty is high and fifoFull is low.
- R2: In 5-repeat mode (modeSel low at the fetch), each 20-bit payload word takes up 5 consecutive txWord outputs. Stream bit p, which is bit p mod 20 of output number p div 20, equals payload bit p div 5.
- R3: In 11-repeat mode (modeSel high at the fetch), each payload word takes up 11 consecutive txWord outputs. Stream bit p equals payload bit p div 11.
- R4: slotPulse rises exactly once per payload word: 5 cycles after the previous slot in 5-repeat mode and 11 cycles after it in 11-repeat mode. The first slot comes 5 cycles after reset. At each slot with a non-empty buffer, exactly one word is taken from the buffer.
- R5: Two consecutive qualified samples form one payload word, with the earlier sample in bits [9:0] and the later one in bits [19:10].
- R6: modeSel is sampled only at a fetch. A change between fetches has no effect on the word being sent. The new repeat count and its interval start with the word fetched at that slot.
- R7: A slot with an empty buffer raises underflow together with slotPulse for one cycle. The previous payload word is then sent again in full.
- R8: The buffer holds 8 words. fifoFull is high at 8 words, and a word completed while the buffer is full is discarded and never sent.
- R9: fifoEmpty is high exactly when the buffer holds no words, and fifoFull and fifoEmpty are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (transceiver word) clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 1 | Repeat select, 0 = 5 repeats, 1 = 11 repeats; sampled at fetch slots |
| sampleValid | input | 1 | Qualifies sampleIn for this cycle |
| sampleIn | input | 10 | Video sample |
| txWord | output | 20 | Oversampled transceiver word, earliest bit in bit 0 |
| slotPulse | output | 1 | High for the cycle in which a new payload word starts on txWord |
| underflow | output | 1 | High with slotPulse when that slot found the buffer empty |
| fifoFull | output | 1 | Buffer holds 8 words |
| fifoEmpty | output | 1 | Buffer holds no words |

## Verification
The repetition path is tried in both modes with samples fed at the exact consumption rate and with distinct sample values. A pair swap or a wrong repeat count therefore shows up as a bit-position mismatch on txWord. Toggling modeSel between fetches shows whether the mode is sampled only at word boundaries rather than mid-word. Stopping the input separates repeat-on-underflow from sending stale or zero data. Feeding every cycle in 11-repeat mode fills the buffer, which shows whether overflow words are dropped rather than overwriting queued ones.

// File: rtl/txos_pkg.sv
package txos_pkg;
  localparam int SAMPLE_W   = 10;
  localparam int WORD_W     = 2 * SAMPLE_W;
  localparam int FIFO_DEPTH = 8;
  localparam int REP_LO     = 5;
  localparam int REP_HI     = 11;
  localparam int PHASE_W    = $clog2(REP_HI);

  // Strobes from control to datapath
  typedef struct packed {
    logic               pop;     // take one word from the buffer this cycle
    logic               hiMode;  // active repeat count is REP_HI
    logic [PHASE_W-1:0] phase;   // output word index within the payload word
  } osStrobes_t;
endpackage

// File: rtl/txos_fifo.sv
module txos_fifo #(
  parameter int WIDTH = txos_pkg::WORD_W,
  parameter int DEPTH = txos_pkg::FIFO_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doWr, doRd;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doWr   = wrEn & ~full;
  assign doRd   = rdEn & ~empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txos_control.sv
module txos_control
  import txos_pkg::*;
#(
  parameter int REP_A = txos_pkg::REP_LO,
  parameter int REP_B = txos_pkg::REP_HI
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       fifoEmpty,
  output osStrobes_t strb,
  output logic       slotPulse,
  output logic       underflow
);
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] lastPhase;
  logic               hiMode;
  logic               slot;

  assign lastPhase = hiMode ? PHASE_W'(REP_B - 1) : PHASE_W'(REP_A - 1);
  assign slot      = (phase == lastPhase);

  assign strb.pop    = slot & ~fifoEmpty;
  assign strb.hiMode = hiMode;
  assign strb.phase  = phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      hiMode    <= 1'b0;
      slotPulse <= 1'b0;
      underflow <= 1'b0;
    end else begin
      slotPulse <= slot;
      underflow <= slot & fifoEmpty;
      if (slot) begin
        phase  <= '0;
        hiMode <= modeSel;   // mode only changes at a word boundary
      end else begin
        phase  <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txos_datapath.sv
module txos_datapath
  import txos_pkg::*;
#(
  parameter int SMP_W = txos_pkg::SAMPLE_W,
  parameter int DEPTH = txos_pkg::FIFO_DEPTH,
  parameter int REP_A = txos_pkg::REP_LO,
  parameter int REP_B = txos_pkg::REP_HI
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [SMP_W-1:0]   sampleIn,
  input  osStrobes_t         strb,
  output logic               fifoEmpty,
  output logic               fifoFull,
  output logic [2*SMP_W-1:0] txWord
);
  localparam int WW    = 2 * SMP_W;
  localparam int IDX_W = $clog2(REP_B * WW);

  // Sample pairing: earlier sample goes to the low half
  logic             haveLow;
  logic [SMP_W-1:0] lowSample;
  logic             pairWr;
  logic [WW-1:0]    pairWord;

  assign pairWr   = sampleValid & haveLow;
  assign pairWord = {sampleIn, lowSample};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLow   <= 1'b0;
      lowSample <= '0;
    end else if (sampleValid) begin
      if (haveLow) begin
        haveLow   <= 1'b0;
      end else begin
        haveLow   <= 1'b1;
        lowSample <= sampleIn;
      end
    end
  end

  logic [WW-1:0] headWord;

  txos_fifo #(.WIDTH(WW), .DEPTH(DEPTH)) i_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (pairWr),
    .wrData (pairWord),
    .rdEn   (strb.pop),
    .rdData (headWord),
    .full   (fifoFull),
    .empty  (fifoEmpty)
  );

  // Payload word being sent; kept when a slot finds the buffer empty
  logic [WW-1:0] curWord;

  always_ff @(posedge clk) begin
    if (!rstN)         curWord <= '0;
    else if (strb.pop) curWord <= headWord;
  end

  function automatic logic pickBit(input logic [WW-1:0] w, input logic [IDX_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < WW; k++) begin
      if (idx == IDX_W'(k)) r = w[k];
    end
    return r;
  endfunction

  // Output bit j of phase q carries stream position q*WW + j
  logic [WW-1:0] expanded;

  for (genvar j = 0; j < WW; j++) begin : g_bit
    logic [IDX_W-1:0] posIdx, srcA, srcB;
    assign posIdx      = IDX_W'(strb.phase) * IDX_W'(WW) + IDX_W'(j);
    assign srcA        = posIdx / IDX_W'(REP_A);
    assign srcB        = posIdx / IDX_W'(REP_B);
    assign expanded[j] = strb.hiMode ? pickBit(curWord, srcB) : pickBit(curWord, srcA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) txWord <= '0;
    else       txWord <= expanded;
  end
endmodule

// File: rtl/txos_oversampler.sv
module txos_oversampler
  import txos_pkg::*;
#(
  parameter int SMP_W = txos_pkg::SAMPLE_W,
  parameter int DEPTH = txos_pkg::FIFO_DEPTH,
  parameter int REP_A = txos_pkg::REP_LO,
  parameter int REP_B = txos_pkg::REP_HI
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSel,
  input  logic               sampleValid,
  input  logic [SMP_W-1:0]   sampleIn,
  output logic [2*SMP_W-1:0] txWord,
  output logic               slotPulse,
  output logic               underflow,
  output logic               fifoFull,
  output logic               fifoEmpty
);
  osStrobes_t strb;

  txos_control #(.REP_A(REP_A), .REP_B(REP_B)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .fifoEmpty (fifoEmpty),
    .strb      (strb),
    .slotPulse (slotPulse),
    .underflow (underflow)
  );

  txos_datapath #(.SMP_W(SMP_W), .DEPTH(DEPTH), .REP_A(REP_A), .REP_B(REP_B)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .strb        (strb),
    .fifoEmpty   (fifoEmpty),
    .fifoFull    (fifoFull),
    .txWord      (txWord)
  );
endmodule

// File: rtl/txos_checker.sv
module txos_checker #(
  parameter int REP_A = txos_pkg::REP_LO,
  parameter int REP_B = txos_pkg::REP_HI
) (
  input logic clk,
  input logic rstN,
  input logic slotPulse,
  input logic underflow,
  input logic fifoFull,
  input logic fifoEmpty
);
  localparam int GAP_W = $clog2(REP_B + 2);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rstN)          gap <= '0;
    else if (slotPulse) gap <= GAP_W'(1);
    else if (gap != GAP_MAX) gap <= gap + 1'b1;
  end

  // R4: slots come at the repeat interval of the active mode
  p_slot_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    slotPulse |-> (gap == GAP_W'(REP_A) || gap == GAP_W'(REP_B)));

  // R7: underflow is reported only at a fetch slot
  p_uf_at_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> slotPulse);

  // R9: full and empty never together
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  // R8: an empty buffer cannot be full one cycle later (one word per cycle at most)
  p_fill_rate_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |=> !fifoFull);
endmodule

bind txos_oversampler txos_checker #(.REP_A(REP_A), .REP_B(REP_B)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .slotPulse (slotPulse),
  .underflow (underflow),
  .fifoFull  (fifoFull),
  .fifoEmpty (fifoEmpty)
);

// File: tb/test_txos_oversampler.sv
module test_txos_oversampler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic        sampleValid = 1'b0;
  logic [9:0]  sampleIn = '0;
  logic [19:0] txWord;
  logic        slotPulse, underflow, fifoFull, fifoEmpty;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  txos_oversampler i_txos_oversampler (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sampleValid(sampleValid),
    .sampleIn(sampleIn), .txWord(txWord), .slotPulse(slotPulse),
    .underflow(underflow), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  // Reference model state (from the requirements)
  int          mPhase, mN, mHead, mCount;
  logic [19:0] mWord;
  logic [19:0] mQ [8];
  logic        mHaveLow;
  logic [9:0]  mLow;
  logic [19:0] eTx;
  logic        eSlot, eUf;
  int          ufSeen, fullSeen, gap11Seen, lastSlotCycle, cycleNo;

  function automatic logic [19:0] streamSlice(input logic [19:0] w, input int n, input int ph);
    logic [219:0] st;
    st = '0;
    for (int b = 0; b < 20; b++)
      for (int r = 0; r < n; r++)
        st[b*n + r] = w[b];
    return st[ph*20 +: 20];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; sampleValid = 1'b0; modeSel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mPhase = 0; mN = 5; mHead = 0; mCount = 0; mWord = '0;
    mHaveLow = 1'b0; mLow = '0;
    ufSeen = 0; fullSeen = 0; gap11Seen = 0; lastSlotCycle = 0; cycleNo = 0;
  endtask

  task automatic stepCycle(input logic v, input logic [9:0] s, input logic m, input string req);
    bit fullPre;
    sampleValid = v; sampleIn = s; modeSel = m;
    @(posedge clk);
    eTx   = streamSlice(mWord, mN, mPhase);
    eSlot = (mPhase == mN - 1);
    eUf   = eSlot && (mCount == 0);
    fullPre = (mCount == 8);
    if (eSlot) begin
      if (mCount > 0) begin
        mWord = mQ[mHead]; mHead = (mHead + 1) % 8; mCount--;
      end
      mPhase = 0; mN = m ? 11 : 5;
    end else mPhase++;
    if (v) begin
      if (mHaveLow) begin
        if (!fullPre) begin mQ[(mHead + mCount) % 8] = {s, mLow}; mCount++; end
        mHaveLow = 1'b0;
      end else begin
        mLow = s; mHaveLow = 1'b1;
      end
    end
    @(negedge clk);
    cycleNo++;
    check(txWord === eTx, req, "txWord", 32'(txWord), 32'(eTx));
    check(slotPulse === eSlot && underflow === eUf, req, "slot/underflow",
          {30'd0, slotPulse, underflow}, {30'd0, eSlot, eUf});
    check(fifoEmpty === (mCount == 0) && fifoFull === (mCount == 8), "R9", "empty/full",
          {30'd0, fifoFull, fifoEmpty}, {30'd0, mCount == 8, mCount == 0});
    if (underflow) ufSeen++;
    if (fifoFull) fullSeen++;
    if (slotPulse) begin
      if (cycleNo - lastSlotCycle == 11) gap11Seen++;
      lastSlotCycle = cycleNo;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(txWord == '0 && !slotPulse && !underflow && fifoEmpty && !fifoFull, "R1",
          "reset outputs", {9'd0, txWord, slotPulse, underflow, fifoFull, fifoEmpty},
          {9'd0, 20'd0, 4'b0001});
    doReset();
    stepCycle(1'b0, '0, 1'b0, "R1");
  endtask

  task automatic testStream5();
    doReset();
    for (int i = 0; i < 150; i++)
      stepCycle((i % 5) < 2, 10'(10'h155 ^ (i * 37)), 1'b0, "R2");
    check(ufSeen == 0, "R5", "no underflow at balanced rate", 32'(ufSeen), 32'd0);
  endtask

  task automatic testStream11();
    doReset();
    for (int i = 0; i < 230; i++)
      stepCycle((i % 11) < 2, 10'(10'h2a3 + i * 91), 1'b1, "R3");
    check(gap11Seen > 0, "R4", "11-cycle slot interval seen", 32'(gap11Seen), 32'd1);
  endtask

  task automatic testModeSwitch();
    doReset();
    for (int i = 0; i < 200; i++)
      stepCycle((i % 5) < 2, 10'(i * 13 + 5), ((i / 7) % 2) == 1, "R6");
    check(gap11Seen > 0, "R6", "switch to 11 repeats took effect", 32'(gap11Seen), 32'd1);
  endtask

  task automatic testUnderflow();
    doReset();
    for (int i = 0; i < 4; i++) stepCycle(1'b1, 10'(10'h3c1 - i * 77), 1'b0, "R7");
    for (int i = 0; i < 40; i++) stepCycle(1'b0, '0, 1'b0, "R7");
    check(ufSeen > 0, "R7", "underflow pulses", 32'(ufSeen), 32'd1);
  endtask

  task automatic testFull();
    doReset();
    for (int i = 0; i < 60; i++) stepCycle(1'b1, 10'(i * 29 + 1), 1'b1, "R8");
    check(fullSeen > 0, "R8", "buffer reached full", 32'(fullSeen), 32'd1);
    for (int i = 0; i < 120; i++) stepCycle(1'b0, '0, 1'b1, "R8");
    check(fifoEmpty === 1'b1, "R8", "drained after dropped words", 32'(fifoEmpty), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testStream5();
    testStream11();
    testModeSwitch();
    testUnderflow();
    testFull();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule